// File: doc/BRIEF.md
# SPI Receive Overrun Detector

This block owns the one-entry receive holding register of a serial port. The shift register pulses a byte-complete strobe with the assembled byte. If the holding register is free, the block stores the byte there and raises the receive-not-empty flag. A data-register read returns the held byte and frees the entry.

If a byte completes while the previous byte is still unread, the block raises an overrun flag and keeps the older byte. While the flag stays up, every further byte is discarded. Software clears the flag with a two-step sequence: first a data read, then a status read in a strictly later cycle. An error-interrupt level output follows the overrun flag, gated by an enable input.

Top module: `spi_rx_ovr`

## Requirements
- R1: After reset, receive-not-empty, overrun and error interrupt are 0, and the data output is all zeros.
- R2: A byte-complete strobe with receive-not-empty at 0 and overrun at 0 stores the byte. One cycle later, receive-not-empty is 1 and the data output shows that byte.
- R3: A data read without a simultaneous store clears receive-not-empty in the next cycle. The data output keeps the held byte.
- R4: A byte-complete strobe while receive-not-empty is 1 sets overrun in the next cycle and leaves the held byte unchanged.
- R5: While overrun is 1, a completed byte is dropped. The held byte does not change and receive-not-empty is not set, even when it is 0.
- R6: Overrun clears only after a status read that comes in a later cycle than a data read made while overrun was set. A status read alone, or one made before the data read, leaves overrun set.
- R7: A data read and a status read in the same cycle only start the clear sequence. Overrun stays set until a later status read.
- R8: If a byte completes in the cycle whose status read would clear overrun, overrun stays set. A later status read then clears it without another data read.
- R9: The error-interrupt output is 1 exactly when overrun is 1 and the enable input is 1, in the same cycle as the enable.
- R10: After overrun clears, the next completed byte is stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_done_i | input | 1 | Byte-complete strobe from the shift register |
| byte_i | input | W | Completed byte |
| dr_rd_i | input | 1 | Data-register read strobe |
| sr_rd_i | input | 1 | Status-register read strobe |
| err_ie_i | input | 1 | Error-interrupt enable |
| rd_data_o | output | W | Held receive byte |
| rxne_o | output | 1 | Receive-not-empty flag |
| ovr_o | output | 1 | Overrun flag |
| err_irq_o | output | 1 | Error-interrupt level |

## Verification
Suppose the armed bit is wrong. If it is missed, a status read after a data read leaves overrun stuck high. If it is set too early, a lone status read clears overrun. Either fault shows on ovr_o one cycle after the status read. If the load gating is wrong, the held byte is overwritten, and rd_data_o shows this one cycle after the dropped strobe. A receive-not-empty flag that fails to set or clear appears on rxne_o in the cycle after the load or the read.

// File: rtl/spi_rx_ovr_pkg.sv
package spi_rx_ovr_pkg;
  localparam int unsigned DEF_W = 8;

  typedef struct packed {
    logic ovr;
    logic armed;
  } ovr_state_t;
endpackage

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         rd_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  logic [W-1:0] data_q;
  logic         full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (load_i) data_q <= byte_i;
      // load wins over a read in the same cycle
      if (load_i)    full_q <= 1'b1;
      else if (rd_i) full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
endmodule

// File: rtl/spi_ovr_track.sv
module spi_ovr_track
  import spi_rx_ovr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byte_done_i,
  input  logic full_i,
  input  logic dr_rd_i,
  input  logic sr_rd_i,
  output logic ovr_o,
  output logic load_ok_o
);
  ovr_state_t st_q, st_d;
  logic set_ovr, clr_ovr;

  assign set_ovr = byte_done_i & full_i;
  // new byte in the clearing cycle keeps the flag
  assign clr_ovr = st_q.ovr & st_q.armed & sr_rd_i & ~byte_done_i;

  always_comb begin
    st_d = st_q;
    if (clr_ovr) begin
      st_d.ovr   = 1'b0;
      st_d.armed = 1'b0;
    end else begin
      if (set_ovr) st_d.ovr = 1'b1;
      if (st_q.ovr && dr_rd_i) st_d.armed = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign ovr_o     = st_q.ovr;
  assign load_ok_o = ~st_q.ovr;
endmodule

// File: rtl/spi_rx_ovr.sv
module spi_rx_ovr
  import spi_rx_ovr_pkg::*;
#(
  parameter int unsigned W = DEF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         byte_done_i,
  input  logic [W-1:0] byte_i,
  input  logic         dr_rd_i,
  input  logic         sr_rd_i,
  input  logic         err_ie_i,
  output logic [W-1:0] rd_data_o,
  output logic         rxne_o,
  output logic         ovr_o,
  output logic         err_irq_o
);
  logic full, load_ok, load;

  assign load = byte_done_i & ~full & load_ok;

  spi_rx_hold #(.W(W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .rd_i   (dr_rd_i),
    .byte_i (byte_i),
    .data_o (rd_data_o),
    .full_o (full)
  );

  spi_ovr_track u_ovr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_done_i (byte_done_i),
    .full_i      (full),
    .dr_rd_i     (dr_rd_i),
    .sr_rd_i     (sr_rd_i),
    .ovr_o       (ovr_o),
    .load_ok_o   (load_ok)
  );

  assign rxne_o    = full;
  assign err_irq_o = ovr_o & err_ie_i;
endmodule

// File: rtl/spi_rx_ovr_chk.sv
module spi_rx_ovr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         byte_done_i,
  input logic [W-1:0] byte_i,
  input logic         dr_rd_i,
  input logic         sr_rd_i,
  input logic         err_ie_i,
  input logic [W-1:0] rd_data_o,
  input logic         rxne_o,
  input logic         ovr_o,
  input logic         err_irq_o
);
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && !rxne_o && !ovr_o) |=> (rxne_o && rd_data_o == $past(byte_i)));

  a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_rd_i && !(byte_done_i && !rxne_o && !ovr_o)) |=> !rxne_o);

  a_r4_set_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && rxne_o) |=> ovr_o);

  a_r5_keep_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o || (byte_done_i && rxne_o)) |=> $stable(rd_data_o));

  a_r6_needs_sr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !sr_rd_i) |=> ovr_o);

  a_r8_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && byte_done_i) |=> ovr_o);

  a_r9_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> (ovr_o && err_ie_i));
endmodule

bind spi_rx_ovr spi_rx_ovr_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_done_i (byte_done_i),
  .byte_i      (byte_i),
  .dr_rd_i     (dr_rd_i),
  .sr_rd_i     (sr_rd_i),
  .err_ie_i    (err_ie_i),
  .rd_data_o   (rd_data_o),
  .rxne_o      (rxne_o),
  .ovr_o       (ovr_o),
  .err_irq_o   (err_irq_o)
);

// File: tb/sim_spi_rx_ovr.sv
`timescale 1ns/1ps
module sim_spi_rx_ovr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bd = 1'b0, dr = 1'b0, sr = 1'b0, ie = 1'b0;
  logic [W-1:0] b = '0;
  logic [W-1:0] data;
  logic rxne, ovr, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_rx_ovr #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_done_i(bd), .byte_i(b),
    .dr_rd_i(dr), .sr_rd_i(sr), .err_ie_i(ie),
    .rd_data_o(data), .rxne_o(rxne), .ovr_o(ovr), .err_irq_o(irq)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle of strobes, return after the edge
  task automatic cyc(logic d, logic [W-1:0] v, logic r, logic s);
    bd = d; b = v; dr = r; sr = s;
    @(posedge clk); #1;
    bd = 0; dr = 0; sr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; ie = 0;
    @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic go_ovr(logic [W-1:0] a);
    cyc(1, a, 0, 0);
    cyc(1, ~a, 0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rxne", rxne, 0); chk("R1 ovr", ovr, 0);
    chk("R1 irq", irq, 0);   chk("R1 data", data, 0);
  endtask

  task automatic t_load_read();
    do_reset();
    cyc(1, 8'hA5, 0, 0);
    chk("R2 rxne", rxne, 1); chk("R2 data", data, 8'hA5);
    cyc(0, 0, 1, 0);
    chk("R3 rxne", rxne, 0); chk("R3 data", data, 8'hA5);
    cyc(1, 8'h5A, 0, 0);
    chk("R2 second byte", data, 8'h5A);
  endtask

  task automatic t_overrun();
    do_reset();
    go_ovr(8'hA5);
    chk("R4 ovr", ovr, 1); chk("R4 data", data, 8'hA5);
    cyc(1, 8'h77, 0, 0);
    chk("R5 data kept", data, 8'hA5);
    cyc(0, 0, 1, 0);
    chk("R3 rxne in ovr", rxne, 0);
    cyc(1, 8'h88, 0, 0);
    chk("R5 rxne not set", rxne, 0); chk("R5 data", data, 8'hA5);
    chk("R5 ovr", ovr, 1);
    cyc(0, 0, 0, 1);
    chk("R6 cleared", ovr, 0);
    cyc(1, 8'h11, 0, 0);
    chk("R10 load", data, 8'h11); chk("R10 rxne", rxne, 1);
  endtask

  task automatic t_order();
    do_reset();
    go_ovr(8'h3C);
    cyc(0, 0, 0, 1);
    chk("R6 sr alone", ovr, 1);
    cyc(0, 0, 1, 0);
    chk("R6 sr before dr", ovr, 1);
    cyc(0, 0, 0, 1);
    chk("R6 clear", ovr, 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    go_ovr(8'h42);
    cyc(0, 0, 1, 1);
    chk("R7 same cycle", ovr, 1);
    cyc(0, 0, 0, 1);
    chk("R7 later sr", ovr, 0);
  endtask

  task automatic t_collide();
    do_reset();
    go_ovr(8'h21);
    cyc(0, 0, 1, 0);
    cyc(1, 8'h99, 0, 1);
    chk("R8 ovr kept", ovr, 1); chk("R8 data", data, 8'h21);
    chk("R8 rxne", rxne, 0);
    cyc(0, 0, 0, 1);
    chk("R8 later clear", ovr, 0);
  endtask

  task automatic t_irq();
    do_reset();
    ie = 1; #1;
    chk("R9 idle", irq, 0);
    go_ovr(8'h10);
    chk("R9 on", irq, 1);
    ie = 0; #1;
    chk("R9 masked", irq, 0);
    ie = 1; #1;
    chk("R9 unmask", irq, 1);
  endtask

  initial begin
    t_reset();
    t_load_read();
    t_overrun();
    t_order();
    t_same_cycle();
    t_collide();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule